// File: doc/BRIEF.md
# UART Interrupt Identification Controller

This block is the interrupt arbiter of a 16550-style UART. It holds the four-bit interrupt enable register. It watches the line status error bits, the receive data-ready flag, the receive FIFO level against its trigger, a character-timeout pending flag and the modem delta bits. From these it builds a registered interrupt identification byte and a single interrupt request line. It also owns the hidden "holding register empty" pending flag and the transmitter-empty (TEMT) status bit. Register accesses and the transmit-done event set and clear these two bits.

The block sits between the register decode of the UART and the FIFO, shifter and baud logic, which live elsewhere. Each register access reaches it as a single-cycle strobe. The identification byte and the request line are registered, so they reflect the state one clock after any change.

Top module: `uart_iid_ctrl`

## Requirements
- R1: An enable write stores only bits 3:0 of `ier_wdata`, and `ier_rdata` returns them with bits 7:4 at zero. Bit 0 enables receive data, bit 1 enables holding-register empty, bit 2 enables line status and bit 3 enables modem status.
- R2: The identification code in `iir_rdata[3:0]` follows a fixed priority, from highest to lowest. Line status (bit 2 enabled, any `lsr_err` bit set) gives 0x6. Character timeout gives 0xC. Receive data gives 0x4. Holding-register empty (bit 1 enabled, pending flag set) gives 0x2. Modem status (bit 3 enabled, any `msr_delta` bit set) gives 0x0.
- R3: The character-timeout code 0xC appears only while enable bit 0 is set. It has no enable bit of its own.
- R4: With `fifo_en` high, the receive-data code 0x4 needs `rx_ready` and `rx_level >= rx_trig`. With `fifo_en` low, `rx_ready` alone is enough.
- R5: With nothing pending, `iir_rdata[3:0]` is 0x1. `iir_rdata[7:4]` is 0xC while `fifo_en` is high and 0x0 otherwise, whatever code is reported.
- R6: An `iir_rd` strobe while the registered code is 0x2 clears the pending flag. A `thr_wr` strobe also clears it.
- R7: An enable write while `thre` is high sets the pending flag.
- R8: A `tx_done` pulse with `thre` high sets both `temt` and the pending flag. A `thr_wr` strobe clears `temt`.
- R9: `irq` and `iir_rdata` are registered. They show the state sampled at the previous clock edge, and `irq` is high exactly when that code is not 0x1.
- R10: After reset, `iir_rdata` is 0x01, `ier_rdata` is 0x00, `irq` is 0, `temt` is 1 and the pending flag is 0.
- R11: When the pending flag sees a set and a read-clear in the same cycle, the set wins. When `thr_wr` falls in the same cycle as a set, `thr_wr` wins for both the pending flag and `temt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register contents, zero-extended |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Registered identification byte |
| thr_wr | input | 1 | Holding register write strobe |
| tx_done | input | 1 | Transmit completion event |
| thre | input | 1 | Holding register empty status |
| lsr_err | input | 4 | Overrun, parity, framing and break flags |
| rx_ready | input | 1 | Receive data ready |
| fifo_en | input | 1 | FIFO mode enabled |
| rx_level | input | CNT_W | Receive FIFO fill count |
| rx_trig | input | CNT_W | Receive FIFO trigger level |
| char_tmo | input | 1 | Character timeout pending |
| msr_delta | input | 4 | Modem status delta bits |
| temt | output | 1 | Transmitter fully empty |
| irq | output | 1 | Interrupt request |

## Verification
Two updates of the hidden pending flag can land in one clock. One is the read-clear caused by an identification read that reports 0x2. The other is a re-arm from a transmit-done pulse or an enable write with `thre` high. A holding-register write can also coincide with a transmit-done pulse. The bench provokes each overlap by pulsing both strobes in the same cycle while the registered code is 0x2. It judges the outcome through the identification byte and `temt` in the following cycles, against a behavioural model that applies the stated precedence.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

  typedef enum logic [3:0] {
    IID_MODEM   = 4'h0,
    IID_NONE    = 4'h1,
    IID_THRE    = 4'h2,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_code_e;

  localparam logic [3:0] FIFO_MARK = 4'hC;

  // enable bit positions
  localparam int EN_RX    = 0;
  localparam int EN_THR   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;

  // fixed five-level priority pick
  function automatic iid_code_e iid_pick(
    input logic [3:0] en,
    input logic       line_any,
    input logic       tmo,
    input logic       rx_avail,
    input logic       thr_pend,
    input logic       modem_any
  );
    if (en[EN_LINE] && line_any)        return IID_LINE;
    else if (en[EN_RX] && tmo)          return IID_TIMEOUT;
    else if (en[EN_RX] && rx_avail)     return IID_RXDATA;
    else if (en[EN_THR] && thr_pend)    return IID_THRE;
    else if (en[EN_MODEM] && modem_any) return IID_MODEM;
    else                                return IID_NONE;
  endfunction

  // receive-data availability against trigger
  function automatic logic rx_avail_f(
    input logic       ready,
    input logic       fifo_on,
    input logic [7:0] level,
    input logic [7:0] trig
  );
    return ready && (!fifo_on || (level >= trig));
  endfunction

endpackage

// File: rtl/uart_iid_rxavail.sv
module uart_iid_rxavail
  import uart_iid_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             rx_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_trig,
  output logic             rx_avail
);
  localparam int PAD = 8 - CNT_W;

  logic [7:0] lvl8, trg8;

  generate
    if (PAD > 0) begin : g_pad
      assign lvl8 = {{PAD{1'b0}}, rx_level};
      assign trg8 = {{PAD{1'b0}}, rx_trig};
    end else begin : g_cut
      assign lvl8 = rx_level[7:0];
      assign trg8 = rx_trig[7:0];
    end
  endgenerate

  assign rx_avail = rx_avail_f(rx_ready, fifo_en, lvl8, trg8);
endmodule

// File: rtl/uart_iid_thrpend.sv
module uart_iid_thrpend (
  input  logic clk,
  input  logic rst_n,
  input  logic thr_wr,
  input  logic rd_clear,
  input  logic rearm,
  input  logic tx_done,
  input  logic thre,
  output logic thr_pend,
  output logic temt
);
  logic tx_set;
  logic pend_set;

  assign tx_set   = tx_done && thre;
  assign pend_set = rearm || tx_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_pend <= 1'b0;
      temt     <= 1'b1;
    end else begin
      // holding write dominates, then set, then read-clear
      if (thr_wr)        thr_pend <= 1'b0;
      else if (pend_set) thr_pend <= 1'b1;
      else if (rd_clear) thr_pend <= 1'b0;

      if (thr_wr)      temt <= 1'b0;
      else if (tx_set) temt <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_iid_ctrl.sv
module uart_iid_ctrl
  import uart_iid_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  output logic [7:0]       ier_rdata,
  input  logic             iir_rd,
  output logic [7:0]       iir_rdata,
  input  logic             thr_wr,
  input  logic             tx_done,
  input  logic             thre,
  input  logic [3:0]       lsr_err,
  input  logic             rx_ready,
  input  logic             fifo_en,
  input  logic [CNT_W-1:0] rx_level,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             char_tmo,
  input  logic [3:0]       msr_delta,
  output logic             temt,
  output logic             irq
);
  logic [3:0] ier_q;
  logic [7:0] iir_q;
  logic       irq_q;

  // named internal events for the checker
  logic       rx_avail;
  logic       thr_pend;
  logic       rd_clear;
  logic       rearm;
  iid_code_e  code_nxt;

  uart_iid_rxavail #(.CNT_W(CNT_W)) i_rxavail (
    .rx_ready (rx_ready),
    .fifo_en  (fifo_en),
    .rx_level (rx_level),
    .rx_trig  (rx_trig),
    .rx_avail (rx_avail)
  );

  assign rd_clear = iir_rd && (iir_q[3:0] == IID_THRE);
  assign rearm    = ier_wr && thre;

  uart_iid_thrpend i_thrpend (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr_wr   (thr_wr),
    .rd_clear (rd_clear),
    .rearm    (rearm),
    .tx_done  (tx_done),
    .thre     (thre),
    .thr_pend (thr_pend),
    .temt     (temt)
  );

  assign code_nxt = iid_pick(ier_q, |lsr_err, char_tmo, rx_avail,
                             thr_pend, |msr_delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= 4'h0;
      iir_q <= {4'h0, IID_NONE};
      irq_q <= 1'b0;
    end else begin
      if (ier_wr) ier_q <= ier_wdata[3:0];
      iir_q <= {(fifo_en ? FIFO_MARK : 4'h0), code_nxt};
      irq_q <= (code_nxt != IID_NONE);
    end
  end

  assign ier_rdata = {4'h0, ier_q};
  assign iir_rdata = iir_q;
  assign irq       = irq_q;
endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ier_wr,
  input logic [7:0] ier_wdata,
  input logic [7:0] ier_rdata,
  input logic       iir_rd,
  input logic [7:0] iir_rdata,
  input logic       thr_wr,
  input logic       tx_done,
  input logic       thre,
  input logic [3:0] lsr_err,
  input logic       temt,
  input logic       irq,
  input logic       thr_pend,
  input logic [3:0] code_nxt
);

  p_ier_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr |=> ier_rdata == {4'h0, $past(ier_wdata[3:0])});

  p_line_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_rdata[2] && (lsr_err != 4'h0)) |=> iir_rdata[3:0] == 4'h6);

  p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ier_rdata[0] |=> (iir_rdata[3:0] != 4'hC) && (iir_rdata[3:0] != 4'h4));

  p_thrwr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !thr_pend && !temt);

  p_rdclear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:0] == 4'h2 && !thr_wr && !ier_wr && !tx_done)
      |=> !thr_pend);

  p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_wr && thre && !thr_wr) |=> thr_pend);

  p_txdone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && thre && !thr_wr) |=> temt && thr_pend);

  p_irq_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == ($past(code_nxt) != 4'h1));

endmodule

bind uart_iid_ctrl uart_iid_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ier_wr    (ier_wr),
  .ier_wdata (ier_wdata),
  .ier_rdata (ier_rdata),
  .iir_rd    (iir_rd),
  .iir_rdata (iir_rdata),
  .thr_wr    (thr_wr),
  .tx_done   (tx_done),
  .thre      (thre),
  .lsr_err   (lsr_err),
  .temt      (temt),
  .irq       (irq),
  .thr_pend  (thr_pend),
  .code_nxt  (code_nxt)
);

// File: tb/test_uart_iid_ctrl.sv
module test_uart_iid_ctrl;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ier_wr = 0, iir_rd = 0, thr_wr = 0, tx_done = 0, thre = 0;
  logic [7:0]    ier_wdata = 0;
  logic [3:0]    lsr_err = 0, msr_delta = 0;
  logic          rx_ready = 0, fifo_en = 0, char_tmo = 0;
  logic [CW-1:0] rx_level = 0, rx_trig = 0;
  logic [7:0]    ier_rdata, iir_rdata;
  logic          temt, irq;

  always #10 clk = ~clk;

  uart_iid_ctrl #(.CNT_W(CW)) i_uart_iid_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
    .ier_rdata(ier_rdata), .iir_rd(iir_rd), .iir_rdata(iir_rdata),
    .thr_wr(thr_wr), .tx_done(tx_done), .thre(thre), .lsr_err(lsr_err),
    .rx_ready(rx_ready), .fifo_en(fifo_en), .rx_level(rx_level),
    .rx_trig(rx_trig), .char_tmo(char_tmo), .msr_delta(msr_delta),
    .temt(temt), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  string tag = "R10";

  // behavioural reference state
  int m_ier, m_pend, m_temt, m_iir, m_irq;

  task automatic model_reset();
    m_ier = 0; m_pend = 0; m_temt = 1; m_iir = 1; m_irq = 0;
  endtask

  task automatic model_edge();
    int code, nxt_pend;
    bit rxa;
    if (!rst_n) begin
      model_reset();
      return;
    end
    rxa = rx_ready && (fifo_en == 0 || int'(rx_level) >= int'(rx_trig));
    code = 1;
    if ((m_ier & 8) != 0 && msr_delta != 0) code = 0;
    if ((m_ier & 2) != 0 && m_pend != 0)    code = 2;
    if ((m_ier & 1) != 0 && rxa)            code = 4;
    if ((m_ier & 1) != 0 && char_tmo)       code = 12;
    if ((m_ier & 4) != 0 && lsr_err != 0)   code = 6;
    nxt_pend = m_pend;
    if (iir_rd && (m_iir % 16) == 2) nxt_pend = 0;
    if ((ier_wr || tx_done) && thre) nxt_pend = 1;
    if (thr_wr) nxt_pend = 0;
    if (tx_done && thre) m_temt = 1;
    if (thr_wr) m_temt = 0;
    m_pend = nxt_pend;
    if (ier_wr) m_ier = ier_wdata % 16;
    m_iir = code + (fifo_en ? 192 : 0);
    m_irq = (code != 1);
  endtask

  task automatic check(string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("iir", int'(iir_rdata), m_iir);
    check("irq", int'(irq), m_irq);
    check("ier", int'(ier_rdata), m_ier);
    check("temt", int'(temt), m_temt);
    ier_wr = 0; iir_rd = 0; thr_wr = 0; tx_done = 0;
  endtask

  task automatic wr_ier(int v);
    ier_wdata = 8'(v); ier_wr = 1; tick(); tick();
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    @(negedge clk);
    tag = "R10"; tick(); tick();
    rst_n = 1; tick();

    tag = "R1"; wr_ier(8'hFF); wr_ier(8'hA5); wr_ier(0);

    tag = "R5"; fifo_en = 1; tick(); tick(); fifo_en = 0; tick();

    tag = "R4"; wr_ier(1); fifo_en = 1; rx_ready = 1; rx_trig = 8;
    rx_level = 7; tick(); tick();
    rx_level = 8; tick(); tick();
    rx_level = 16; tick();
    fifo_en = 0; rx_level = 0; tick(); tick();
    rx_ready = 0; tick();

    tag = "R3"; char_tmo = 1; tick(); tick();
    wr_ier(0); tick(); char_tmo = 0; tick();

    tag = "R2"; thre = 1; wr_ier(4'hF);
    lsr_err = 4'h2; char_tmo = 1; rx_ready = 1; msr_delta = 4'h4; tick(); tick();
    lsr_err = 0; tick(); tick();
    char_tmo = 0; tick(); tick();
    rx_ready = 0; tick(); tick();
    tag = "R6"; iir_rd = 1; tick(); tick();
    tag = "R2"; msr_delta = 0; tick(); tick();

    tag = "R7"; wr_ier(4'h2); tick();
    tag = "R6"; thr_wr = 1; tick(); tick();
    tag = "R7"; thre = 0; wr_ier(4'h2); thre = 1; tick();

    tag = "R8"; tx_done = 1; tick(); tick();
    thr_wr = 1; tick(); tick();
    thre = 0; tx_done = 1; tick(); tick(); thre = 1;

    tag = "R11"; tx_done = 1; tick(); tick();
    iir_rd = 1; tx_done = 1; tick(); tick();
    iir_rd = 1; ier_wdata = 8'h02; ier_wr = 1; tick(); tick();
    thr_wr = 1; tx_done = 1; tick(); tick();
    iir_rd = 1; tick(); tick();

    tag = "R9"; wr_ier(4'h8); msr_delta = 4'h1; tick(); msr_delta = 0; tick(); tick();
    fifo_en = 1; msr_delta = 4'h8; tick(); tick();

    tag = "R10"; rst_n = 0; tick(); tick(); rst_n = 1; tick();
    finish_run();
  end
endmodule